// File: doc/BRIEF.md
# Supply-Tracking Limiter Threshold Generator

This block produces the peak-level threshold that an audio limiter compares its output against. Each time a new supply-voltage sample arrives with its strobe, the block takes that sample and the programmed settings and computes a fresh threshold word. It then holds that word until the next strobe. The limiter that consumes the threshold, the supply measurement and the register file are outside the block.

Two ways of deriving the threshold are offered.

- **Tracking mode.** A fixed ceiling applies while the supply is healthy. Once the supply sags below a programmed knee voltage, the ceiling is lowered in proportion to the sag, using a programmable gain. A programmed floor then stops any further reduction.
- **Headroom mode.** The threshold is a signed percentage away from the supply itself, with a fixed 1 V/V relation. A negative headroom sets the limit above the rail, which allows a fixed amount of clipping. A positive headroom sets it below the rail, which prevents clipping.

All voltages and the gain are unsigned fixed point with 8 integer and 24 fraction bits. The computation runs through two register stages. The threshold and its valid flag therefore change two clocks after the strobe.

Top module: `lim_thresh_gen`

## Requirements
- R1: In tracking mode (mode_sel = 0), when the supply sample is at or above knee_v and floor_v ≤ ceil_v, the threshold equals ceil_v.
- R2: In tracking mode, with the supply below knee_v, the reduction is (gain × (knee_v − supply)) >> 24. It is saturated to 0xFFFFFFFF when it exceeds 32 bits. The threshold before the floor is ceil_v minus that reduction, or 0 if the reduction is ≥ ceil_v.
- R3: The gain is an unsigned Q8.24 value. 0x01000000 is 1 V/V, and gains above 1 V/V (for example 2.5 V/V = 0x02800000) steepen the reduction accordingly.
- R4: In tracking mode, the threshold is the larger of floor_v and the R2 value. It is never below floor_v.
- R5: In headroom mode (mode_sel = 1), the threshold is floor(supply × (100 − h) / 100). h is headroom_pct read as a 5-bit two's-complement number (−16 to +15). The result saturates to 0xFFFFFFFF when it does not fit in 32 bits. floor_v and ceil_v have no effect in this mode.
- R6: In headroom mode, a negative headroom gives a threshold at or above the supply (−10 gives 1.1 × supply), and a positive headroom gives one at or below it (+10 gives 0.9 × supply).
- R7: The mode, supply and all settings are sampled only on a clock edge where sup_vld is 1.
- R8: A strobe sampled on clock edge k updates thr_out on edge k+2, and thr_vld is 1 from that edge on.
- R9: Without a strobe, thr_out keeps its value even when supply or settings change, and thr_vld stays 1 once set.
- R10: While rst_n is 0, thr_out is 0 and thr_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_vld | input | 1 | Strobe: sup_v holds a new sample |
| sup_v | input | 32 | Supply sample, Q8.24 volts |
| mode_sel | input | 1 | 0 = tracking, 1 = headroom |
| ceil_v | input | 32 | Maximum threshold, Q8.24 |
| knee_v | input | 32 | Inflection (knee) voltage, Q8.24 |
| gain | input | 32 | Tracking gain, Q8.24 V/V |
| floor_v | input | 32 | Minimum threshold in tracking mode, Q8.24 |
| headroom_pct | input | 5 | Signed headroom percentage |
| thr_out | output | 32 | Threshold, Q8.24 |
| thr_vld | output | 1 | Threshold is valid |

## Verification
The tracking path is tried at several supply positions relative to the knee:

- A supply above the knee separates the ceiling case from the sloped case.
- A supply just below the knee, with unity and steeper gains, shows whether the gain multiplies the sag.
- A deep sag with a large gain drives the reduction past the ceiling and exposes the zero clamp and the floor.
- A floor set above the ceiling shows which of the two wins.

Headroom mode is driven with h = −16, −10, 0, +10 and +15, and with a supply near full scale. These cases tell the sign handling apart from the percentage arithmetic and the saturation. Random supply values, settings and modes are mixed in, and supply and settings are changed between strobes to show that only the strobe samples them.

// File: rtl/lim_thresh_pkg.sv
// Shared types and constants for the limiter threshold generator.
// Assumes: every voltage is unsigned Q8.24; the headroom is signed whole percent.
package lim_thresh_pkg;
    typedef enum logic {
        MODE_TRACK    = 1'b0,
        MODE_HEADROOM = 1'b1
    } lim_mode_e;

    // Divisor for the headroom percentage.
    localparam int unsigned PCT_SCALE = 100;
    // Width of the headroom scale factor (100 - h fits in 8 bits for |h| < 28).
    localparam int unsigned FACTOR_W  = 8;
endpackage

// File: rtl/lim_track_path.sv
// Tracking-mode product: the supply sag below the knee times the gain.
// Assumes: unsigned operands of width W; the product keeps all 2W bits.
module lim_track_path #(
    parameter int W = 32
) (
    input  logic [W-1:0]   sup_v,
    input  logic [W-1:0]   knee_v,
    input  logic [W-1:0]   gain,
    output logic [2*W-1:0] sag_prod
);
    logic [W-1:0] sag;

    // Sag is zero at or above the knee, otherwise knee minus supply.
    always_comb begin
        sag      = (sup_v < knee_v) ? (knee_v - sup_v) : '0;
        sag_prod = {{W{1'b0}}, gain} * {{W{1'b0}}, sag};
    end
endmodule

// File: rtl/lim_headroom_path.sv
// Headroom-mode product: supply times (100 - h), h a signed whole percent.
// Assumes: HR_W small enough that 100 - h stays positive within FACTOR_W bits.
module lim_headroom_path
    import lim_thresh_pkg::*;
#(
    parameter int W    = 32,
    parameter int HR_W = 5
) (
    input  logic [W-1:0]          sup_v,
    input  logic [HR_W-1:0]       headroom_pct,
    output logic [W+FACTOR_W-1:0] hr_prod
);
    localparam int SW = FACTOR_W + 1;

    logic signed [SW-1:0]   h_ext;
    logic signed [SW-1:0]   factor_s;
    logic [FACTOR_W-1:0]    factor;

    // Sign-extend the percentage and form the unsigned scale factor.
    always_comb begin
        h_ext    = SW'($signed(headroom_pct));
        factor_s = SW'(PCT_SCALE) - h_ext;
        factor   = factor_s[FACTOR_W-1:0];
        hr_prod  = {{FACTOR_W{1'b0}}, sup_v} * {{W{1'b0}}, factor};
    end
endmodule

// File: rtl/lim_finalize.sv
// Second stage: scales and saturates the registered products, then applies
// the ceiling subtraction and the floor (tracking) or the percent division
// (headroom). Assumes: products from the first stage; Q8.24 with FRAC = 24.
module lim_finalize
    import lim_thresh_pkg::*;
#(
    parameter int W    = 32,
    parameter int FRAC = 24
) (
    input  lim_mode_e              mode,
    input  logic [2*W-1:0]         sag_prod,
    input  logic [W+FACTOR_W-1:0]  hr_prod,
    input  logic [W-1:0]           ceil_v,
    input  logic [W-1:0]           floor_v,
    output logic [W-1:0]           thr
);
    localparam int PW = 2 * W;
    localparam int SW = PW - FRAC;
    localparam int HW = W + FACTOR_W;

    logic [SW-1:0] sag_scaled;
    logic [W-1:0]  reduction;
    logic [W-1:0]  trk_raw;
    logic [W-1:0]  trk_thr;
    logic [HW-1:0] hr_quot;
    logic [W-1:0]  hr_thr;

    // Tracking: drop fraction bits, saturate, subtract with zero clamp, floor.
    always_comb begin
        sag_scaled = sag_prod[PW-1:FRAC];
        reduction  = (|sag_scaled[SW-1:W]) ? '1 : sag_scaled[W-1:0];
        trk_raw    = (reduction >= ceil_v) ? '0 : (ceil_v - reduction);
        trk_thr    = (trk_raw < floor_v) ? floor_v : trk_raw;
    end

    // Headroom: divide by the percent scale and saturate to W bits.
    always_comb begin
        hr_quot = hr_prod / HW'(PCT_SCALE);
        hr_thr  = (|hr_quot[HW-1:W]) ? '1 : hr_quot[W-1:0];
    end

    // Pick the result of the mode that was sampled with the strobe.
    always_comb begin
        thr = (mode == MODE_HEADROOM) ? hr_thr : trk_thr;
    end
endmodule

// File: rtl/lim_thresh_gen.sv
// Top level: two-stage limiter threshold generator. Stage 1 captures the
// mode, floor and ceiling and both products on a strobe. Stage 2 finishes
// the arithmetic and loads the output register.
// Assumes: synchronous active-low reset; settings matter only on strobe edges.
module lim_thresh_gen
    import lim_thresh_pkg::*;
#(
    parameter int W    = 32,
    parameter int FRAC = 24,
    parameter int HR_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sup_vld,
    input  logic [W-1:0]    sup_v,
    input  logic            mode_sel,
    input  logic [W-1:0]    ceil_v,
    input  logic [W-1:0]    knee_v,
    input  logic [W-1:0]    gain,
    input  logic [W-1:0]    floor_v,
    input  logic [HR_W-1:0] headroom_pct,
    output logic [W-1:0]    thr_out,
    output logic            thr_vld
);
    localparam int PW = 2 * W;
    localparam int HW = W + FACTOR_W;

    logic [PW-1:0] sag_prod_c;
    logic [HW-1:0] hr_prod_c;
    logic [W-1:0]  thr_c;

    logic          s1_vld;
    lim_mode_e     s1_mode;
    logic [PW-1:0] s1_sag_prod;
    logic [HW-1:0] s1_hr_prod;
    logic [W-1:0]  s1_ceil;
    logic [W-1:0]  s1_floor;

    lim_track_path #(.W(W)) u_track (
        .sup_v    (sup_v),
        .knee_v   (knee_v),
        .gain     (gain),
        .sag_prod (sag_prod_c)
    );

    lim_headroom_path #(.W(W), .HR_W(HR_W)) u_headroom (
        .sup_v        (sup_v),
        .headroom_pct (headroom_pct),
        .hr_prod      (hr_prod_c)
    );

    // Stage 1: capture products and settings when a strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld      <= 1'b0;
            s1_mode     <= MODE_TRACK;
            s1_sag_prod <= '0;
            s1_hr_prod  <= '0;
            s1_ceil     <= '0;
            s1_floor    <= '0;
        end else begin
            s1_vld <= sup_vld;
            if (sup_vld) begin
                s1_mode     <= lim_mode_e'(mode_sel);
                s1_sag_prod <= sag_prod_c;
                s1_hr_prod  <= hr_prod_c;
                s1_ceil     <= ceil_v;
                s1_floor    <= floor_v;
            end
        end
    end

    lim_finalize #(.W(W), .FRAC(FRAC)) u_final (
        .mode     (s1_mode),
        .sag_prod (s1_sag_prod),
        .hr_prod  (s1_hr_prod),
        .ceil_v   (s1_ceil),
        .floor_v  (s1_floor),
        .thr      (thr_c)
    );

    // Stage 2: load the threshold one cycle after stage 1; valid is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_out <= '0;
            thr_vld <= 1'b0;
        end else if (s1_vld) begin
            thr_out <= thr_c;
            thr_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/lim_thresh_gen_chk.sv
// Port-level assertions for lim_thresh_gen, attached through bind.
// Assumes: the same parameters as the bound instance.
module lim_thresh_gen_chk #(
    parameter int W    = 32,
    parameter int HR_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sup_vld,
    input logic [W-1:0]    sup_v,
    input logic            mode_sel,
    input logic [W-1:0]    ceil_v,
    input logic [W-1:0]    knee_v,
    input logic [W-1:0]    gain,
    input logic [W-1:0]    floor_v,
    input logic [HR_W-1:0] headroom_pct,
    input logic [W-1:0]    thr_out,
    input logic            thr_vld
);
    // Reset state of the outputs (R10).
    a_r10_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (thr_out == '0 && !thr_vld));

    // A strobe two edges back makes the output valid (R8).
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(sup_vld, 2)) |-> thr_vld);

    // Without a strobe two edges back the threshold holds (R9).
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(sup_vld, 2)) |-> $stable(thr_out));

    // Valid never falls outside reset (R9).
    a_r9_sticky_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(thr_vld)) |-> thr_vld);

    // Supply at or above the knee yields the ceiling (R1).
    a_r1_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(sup_vld, 2) && !$past(mode_sel, 2) &&
         $past(sup_v, 2) >= $past(knee_v, 2) && $past(floor_v, 2) <= $past(ceil_v, 2))
        |-> thr_out == $past(ceil_v, 2));

    // Tracking result never below the floor (R4).
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(sup_vld, 2) && !$past(mode_sel, 2))
        |-> thr_out >= $past(floor_v, 2));

    // Negative headroom puts the threshold at or above the supply (R6).
    a_r6_neg_above: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(sup_vld, 2) && $past(mode_sel, 2) &&
         $past(headroom_pct[HR_W-1], 2))
        |-> thr_out >= $past(sup_v, 2));

    // Positive or zero headroom puts it at or below the supply (R6).
    a_r6_pos_below: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(sup_vld, 2) && $past(mode_sel, 2) &&
         !$past(headroom_pct[HR_W-1], 2))
        |-> thr_out <= $past(sup_v, 2));
endmodule

bind lim_thresh_gen lim_thresh_gen_chk #(.W(W), .HR_W(HR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sup_vld      (sup_vld),
    .sup_v        (sup_v),
    .mode_sel     (mode_sel),
    .ceil_v       (ceil_v),
    .knee_v       (knee_v),
    .gain         (gain),
    .floor_v      (floor_v),
    .headroom_pct (headroom_pct),
    .thr_out      (thr_out),
    .thr_vld      (thr_vld)
);

// File: tb/lim_thresh_gen_test.sv
`timescale 1ns/1ps
module lim_thresh_gen_test;
    localparam logic [31:0] ONE_V = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_vld = 1'b0;
    logic [31:0] sup_v = '0;
    logic        mode_sel = 1'b0;
    logic [31:0] ceil_v = '0;
    logic [31:0] knee_v = '0;
    logic [31:0] gain = '0;
    logic [31:0] floor_v = '0;
    logic [4:0]  headroom_pct = '0;
    logic [31:0] thr_out;
    logic        thr_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lim_thresh_gen uut (
        .clk(clk), .rst_n(rst_n), .sup_vld(sup_vld), .sup_v(sup_v),
        .mode_sel(mode_sel), .ceil_v(ceil_v), .knee_v(knee_v), .gain(gain),
        .floor_v(floor_v), .headroom_pct(headroom_pct),
        .thr_out(thr_out), .thr_vld(thr_vld)
    );

    // Reference threshold computed from the requirements.
    function automatic logic [31:0] ref_thr(input logic m, input logic [31:0] s,
        input logic [31:0] cv, input logic [31:0] kv, input logic [31:0] g,
        input logic [31:0] fv, input logic [4:0] h);
        logic [63:0] p;
        logic [31:0] red, raw;
        int f;
        if (m) begin
            f = 100 - int'($signed(h));
            p = {32'b0, s} * 64'(f) / 64'd100;
            return (p > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : p[31:0];
        end
        p = (s < kv) ? ({32'b0, g} * {32'b0, kv - s}) >> 24 : 64'd0;
        red = (p > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : p[31:0];
        raw = (red >= cv) ? 32'd0 : cv - red;
        return (raw < fv) ? fv : raw;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Strobe one sample, then check at the negedge after two rising edges.
    task automatic run(input string req, input logic m, input logic [31:0] s,
        input logic [31:0] cv, input logic [31:0] kv, input logic [31:0] g,
        input logic [31:0] fv, input logic [4:0] h);
        @(negedge clk);
        mode_sel = m; sup_v = s; ceil_v = cv; knee_v = kv; gain = g;
        floor_v = fv; headroom_pct = h; sup_vld = 1'b1;
        @(negedge clk);
        sup_vld = 1'b0;
        @(negedge clk);
        check(req, thr_out, ref_thr(m, s, cv, kv, g, fv, h));
        check({req, " valid"}, {31'b0, thr_vld}, 32'd1);
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 thr", thr_out, 32'd0);
        check("R10 vld", {31'b0, thr_vld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle vld", {31'b0, thr_vld}, 32'd0);

        // R1: supply above knee gives ceiling
        run("R1", 1'b0, 12*ONE_V, 10*ONE_V, 9*ONE_V, ONE_V, 2*ONE_V, 5'd0);
        check("R1 value", thr_out, 10*ONE_V);
        // R2: 1 V sag at unity gain removes 1 V
        run("R2", 1'b0, 8*ONE_V, 10*ONE_V, 9*ONE_V, ONE_V, 2*ONE_V, 5'd0);
        check("R2 value", thr_out, 9*ONE_V);
        // R3: 2.5 V/V gain with 2 V sag removes 5 V
        run("R3", 1'b0, 7*ONE_V, 10*ONE_V, 9*ONE_V, 32'h0280_0000, 32'd0, 5'd0);
        check("R3 value", thr_out, 5*ONE_V);
        // R4: deep sag clamps at the floor
        run("R4", 1'b0, 0, 10*ONE_V, 9*ONE_V, 32'hFF00_0000, 3*ONE_V, 5'd0);
        check("R4 value", thr_out, 3*ONE_V);
        // R2: reduction beyond ceiling with zero floor gives 0
        run("R2 clamp", 1'b0, 0, 10*ONE_V, 200*ONE_V, 32'hFFFF_FFFF, 0, 5'd0);
        check("R2 clamp value", thr_out, 32'd0);
        // R4: floor above ceiling wins
        run("R4 over", 1'b0, 12*ONE_V, 4*ONE_V, 9*ONE_V, ONE_V, 6*ONE_V, 5'd0);
        // R5/R6: headroom corners
        run("R6 neg10", 1'b1, 10*ONE_V, ONE_V, 0, 0, 50*ONE_V, 5'b10110);
        check("R6 neg10 value", thr_out, 11*ONE_V);
        run("R6 pos10", 1'b1, 10*ONE_V, ONE_V, 0, 0, 50*ONE_V, 5'd10);
        check("R6 pos10 value", thr_out, 9*ONE_V);
        run("R5 zero", 1'b1, 32'h0ABC_DEF1, 0, 0, 0, 0, 5'd0);
        run("R5 min", 1'b1, 32'h1234_5678, 0, 0, 0, 0, 5'b10000);
        run("R5 max", 1'b1, 32'h1234_5679, 0, 0, 0, 0, 5'd15);
        run("R5 sat", 1'b1, 32'hF000_0000, 0, 0, 0, 0, 5'b10000);
        check("R5 sat value", thr_out, 32'hFFFF_FFFF);

        // R7/R9: changes without strobe are ignored
        held = thr_out;
        @(negedge clk);
        sup_v = 32'd5; mode_sel = 1'b0; ceil_v = 32'd77; floor_v = 32'd77;
        repeat (4) @(negedge clk);
        check("R9 hold", thr_out, held);
        check("R9 vld", {31'b0, thr_vld}, 32'd1);
        // R7: stale settings are not used once strobed with new ones
        run("R7", 1'b0, 5*ONE_V, 8*ONE_V, 6*ONE_V, ONE_V, 0, 5'd0);

        // R8: exact latency, output unchanged one edge after strobe
        @(negedge clk);
        held = thr_out;
        mode_sel = 1'b1; sup_v = 20*ONE_V; headroom_pct = 5'd0; sup_vld = 1'b1;
        @(negedge clk);
        sup_vld = 1'b0;
        check("R8 not yet", thr_out, held);
        @(negedge clk);
        check("R8 updated", thr_out, 20*ONE_V);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic m;
            m = 1'($urandom_range(0, 1));
            run(m ? "R5 rnd" : "R2 rnd", m,
                $urandom_range(0, 32'h1800_0000), $urandom_range(0, 32'h1800_0000),
                $urandom_range(0, 32'h1800_0000), $urandom_range(0, 32'h0600_0000),
                $urandom_range(0, 32'h0800_0000), 5'($urandom_range(0, 31)));
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule